// File: doc/BRIEF.md
# Rewindable FIFO with Loadable Half-Full Threshold

This block is a first-in/first-out buffer controller for a single device. Words of a configurable width are written with an active-low write strobe and read back in arrival order with an active-low read strobe. All strobes are sampled on one system clock, and each cycle with a strobe low is one operation. Three active-low flags report full, empty and an occupancy above a programmable threshold. The default build is 9 bits wide and 1024 words deep, and both sizes are parameters.

Reading does not destroy the stored words. A rewind strobe, given while both data strobes are idle, moves the read position back to the first word written since reset, so a block can be sent again. The write position does not move. The half-full threshold is a register. It is loaded from the data inputs by pulling the write strobe low while reset is held, and it falls back to half the depth when no load happens during that reset. The data output counts as driven only while a separate output-enable is high. This models a three-state bus.

Top module: `rewind_fifo`

## Requirements
- R1: `full_n` is low exactly when the occupancy equals DEPTH. A write strobe while full is ignored: the stored words and the occupancy are unchanged, and a read in that same cycle is still accepted.
- R2: `empty_n` is low exactly when the occupancy is zero. A read strobe while empty is ignored: `dout_oe` stays 0 in the next cycle and the read position does not move.
- R3: `half_n` is low exactly when the occupancy is strictly greater than the threshold register. All flags show the occupancy that results from the operations sampled on the previous rising edge.
- R4: In the cycle after an accepted read, `dout_oe` is 1 and `dout` holds the oldest unread word. In every other cycle `dout_oe` is 0.
- R5: A cycle with `rt_n` low and both `wr_n` and `rd_n` high returns the read position to the first word written since reset. The write position is left as it is, and the occupancy becomes the number of words written since reset. With either data strobe low, `rt_n` is ignored.
- R6: After a rewind, `half_n` is recomputed from the new occupancy.
- R7: While `rst` is high, a cycle with `wr_n` low loads the threshold from `din` (zero-extended or truncated to log2(DEPTH)+1 bits) and stores no data. If no such cycle occurs during a reset, the threshold is DEPTH/2.
- R8: After reset the flags are `empty_n`=0, `full_n`=1 and `half_n`=1, and `dout_oe` is 0.
- R9: A cycle with both a write and a read accepted stores the new word, delivers the oldest word, and leaves the occupancy unchanged.
- R10: When the buffer is empty, a read in the same cycle as a write is ignored. The word being written is not visible to that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; threshold load window |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind strobe, active low |
| din | input | WIDTH | Write data; threshold value during reset |
| dout | output | WIDTH | Read data, valid while `dout_oe` is high |
| dout_oe | output | 1 | Output enable for `dout` |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | Above-threshold flag, active low |

## Verification
A write and a read can be sampled on the same edge. This is provoked on purpose in three states: mid-occupancy, where both must happen and the flags must not move; a completely full buffer, where only the read must take effect; and an empty buffer, where only the write may land. A scoreboard model keeps every word written since reset and a read index, and predicts from these which of the two operations is accepted. The delivered words and all three flags are compared against that prediction every cycle. A pseudo-random stretch of mixed strobes then repeats the coincidence in many fill states.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

  // Operations accepted in one clock cycle
  typedef struct packed {
    logic wr;
    logic rd;
    logic rt;
  } op_t;

  // Address width for a given depth (at least one bit)
  function automatic int ptr_w(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/rtf_ctrl.sv
module rtf_ctrl #(
  parameter int DEPTH = 1024,
  localparam int AW = rtf_pkg::ptr_w(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  output rtf_pkg::op_t     op,
  output logic [AW-1:0]    wr_addr,
  output logic [AW-1:0]    rd_addr,
  output logic [CW-1:0]    cnt_nx
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wtot_q;   // words written since reset, saturating at DEPTH
  logic          is_full, is_empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    is_full  = (cnt_q == FULL_CNT);
    is_empty = (cnt_q == '0);
    op.wr    = !rst && !wr_n && !is_full;
    op.rd    = !rst && !rd_n && !is_empty;
    op.rt    = !rst && !rt_n && wr_n && rd_n;
    cnt_nx   = cnt_q;
    if (rst)                    cnt_nx = '0;
    else if (op.rt)             cnt_nx = wtot_q;
    else if (op.wr && !op.rd)   cnt_nx = cnt_q + 1'b1;
    else if (op.rd && !op.wr)   cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      wtot_q <= '0;
    end else begin
      if (op.wr) begin
        wp_q <= bump(wp_q);
        if (wtot_q != FULL_CNT) wtot_q <= wtot_q + 1'b1;
      end
      if (op.rt)      rp_q <= '0;
      else if (op.rd) rp_q <= bump(rp_q);
      cnt_q <= cnt_nx;
    end
  end

  assign wr_addr = wp_q;
  assign rd_addr = rp_q;

  // R1: a write strobe on a full buffer moves nothing
  assert_full_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL_CNT && !wr_n && rd_n) |=> (cnt_q == FULL_CNT && $stable(wp_q)))
    else $error("full buffer accepted a write");

  // R1: occupancy never passes the depth
  assert_count_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT)
    else $error("occupancy above depth");

  // R2: a read strobe on an empty buffer moves nothing
  assert_empty_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !rd_n && wr_n) |=> ($stable(rp_q) && cnt_q == '0))
    else $error("empty buffer accepted a read");

  // R5: rewind clears the read position only
  assert_rewind_R5: assert property (@(posedge clk) disable iff (rst)
    (!rt_n && wr_n && rd_n) |=> (rp_q == '0 && $stable(wp_q)))
    else $error("rewind misbehaved");

  // R9: simultaneous read and write keep the occupancy
  assert_both_R9: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !rd_n && cnt_q != '0 && cnt_q != FULL_CNT) |=> $stable(cnt_q))
    else $error("read+write changed occupancy");

endmodule

// File: rtl/rtf_offset.sv
module rtf_offset #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 1024,
  localparam int CW = rtf_pkg::ptr_w(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] din,
  output logic [CW-1:0]    offset
);

  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  // set once a load happened in the current reset window
  logic ld_seen = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (!wr_n) begin
        offset  <= CW'(din);
        ld_seen <= 1'b1;
      end else if (!ld_seen) begin
        offset  <= HALF;
      end
    end else begin
      ld_seen <= 1'b0;
    end
  end

endmodule

// File: rtl/rtf_flags.sv
module rtf_flags #(
  parameter int DEPTH = 1024,
  localparam int CW = rtf_pkg::ptr_w(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nx,
  input  logic [CW-1:0] offset,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_n  <= 1'b1;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
    end else begin
      full_n  <= (cnt_nx != FULL_CNT);
      empty_n <= (cnt_nx != '0);
      half_n  <= !(cnt_nx > offset);
    end
  end

  // R1: full and empty never both active
  assert_flag_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(!full_n && !empty_n))
    else $error("full and empty both active");

endmodule

// File: rtl/rtf_ram.sv
module rtf_ram #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 1024,
  localparam int AW = rtf_pkg::ptr_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             full_n,
  output logic             empty_n,
  output logic             half_n
);

  localparam int AW = rtf_pkg::ptr_w(DEPTH);
  localparam int CW = AW + 1;

  rtf_pkg::op_t     op;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [CW-1:0]    cnt_nx, offset;
  logic [WIDTH-1:0] rdata;
  logic             rvalid;

  rtf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .op(op), .wr_addr(wr_addr), .rd_addr(rd_addr), .cnt_nx(cnt_nx)
  );

  rtf_offset #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_offset (
    .clk(clk), .rst(rst), .wr_n(wr_n), .din(din), .offset(offset)
  );

  rtf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .cnt_nx(cnt_nx), .offset(offset),
    .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
  );

  rtf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(op.wr), .waddr(wr_addr), .wdata(din),
    .re(op.rd), .raddr(rd_addr), .rdata(rdata), .rvalid(rvalid)
  );

  assign dout_oe = rvalid;
  assign dout    = rvalid ? rdata : '0;

  // R4: output enable only follows a read strobe on a non-empty buffer
  assert_oe_source_R4: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> ($past(!rd_n) && $past(empty_n)))
    else $error("output enabled without an accepted read");

endmodule

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;

  localparam int D = 16;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         dout_oe, full_n, empty_n, half_n;

  int wlist[$];   // every word written since reset
  int rpos;       // model read index into wlist
  int exp_q[$];   // words the monitor must see next
  int off_m;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  rewind_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .full_n(full_n), .empty_n(empty_n),
    .half_n(half_n)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // one cycle of strobes; model update and flag checks
  task automatic cyc(input bit w, input bit r, input bit t, input int d);
    int  occ;
    bit  dw, dr, drt;
    @(negedge clk);
    wr_n = !w; rd_n = !r; rt_n = !t; din = W'(d);
    occ = wlist.size() - rpos;
    drt = t && !w && !r;
    dw  = w && (occ < D);
    dr  = r && (occ > 0);
    if (dr) begin
      exp_q.push_back(wlist[rpos]);
      rpos++;
    end
    if (dw) wlist.push_back(d & 'h1FF);
    if (drt) rpos = 0;
    @(posedge clk); #1;
    occ = wlist.size() - rpos;
    chk(full_n == (occ != D), "R1 full_n", int'(full_n), int'(occ != D));
    chk(empty_n == (occ != 0), "R2 empty_n", int'(empty_n), int'(occ != 0));
    chk(half_n == !(occ > off_m), "R3 half_n", int'(half_n), int'(!(occ > off_m)));
    if (r && !dr)
      chk(dout_oe == 1'b0, w ? "R10 read beside write on empty ignored"
                             : "R2 read on empty ignored", int'(dout_oe), 0);
    if (drt)
      chk(half_n == !(occ > off_m), "R6 half_n after rewind", int'(half_n), int'(!(occ > off_m)));
    if (t)
      chk(empty_n == (occ != 0), drt ? "R5 occupancy after rewind"
                                     : "R5 rewind ignored with strobe low", int'(empty_n), int'(occ != 0));
    if (dw && dr)
      chk(half_n == !(occ > off_m), "R9 occupancy kept on read+write", int'(half_n), int'(!(occ > off_m)));
  endtask

  task automatic do_reset(input bit load, input int val);
    @(negedge clk);
    rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    @(negedge clk);
    if (load) begin
      wr_n = 1'b0;
      din  = W'(val);
    end
    @(negedge clk);
    wr_n = 1'b1; rst = 1'b0;
    wlist.delete(); rpos = 0; exp_q.delete();
    off_m = load ? val : D / 2;
    @(posedge clk); #1;
    chk(full_n == 1'b1, "R8 full_n after reset", int'(full_n), 1);
    chk(empty_n == 1'b0, "R8 empty_n after reset", int'(empty_n), 0);
    chk(half_n == 1'b1, "R8 half_n after reset", int'(half_n), 1);
    chk(dout_oe == 1'b0, "R8 dout_oe after reset", int'(dout_oe), 0);
    if (load) chk(empty_n == 1'b0, "R7 threshold load stored no data", int'(empty_n), 0);
  endtask

  // monitor: compares delivered words against the scoreboard queue (R4)
  initial begin
    forever begin
      @(posedge clk); #2;
      if (!rst) begin
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(dout_oe == 1'b1 && dout == W'(e), "R4 read data", dout_oe ? int'(dout) : -1, e);
        end else if (dout_oe) begin
          chk(1'b0, "R4 unexpected output enable", int'(dout), -1);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    do_reset(1'b0, 0);                       // R8, default threshold D/2 (R7)
    cyc(0, 1, 0, 0);                         // R2 read on empty
    cyc(1, 1, 0, 'h11);                      // R10 write+read on empty
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 'h20 + i);  // R3 crosses 8
    cyc(0, 1, 0, 0);                         // R3 back to 8
    cyc(1, 1, 0, 'h40);                      // R9 mid-occupancy
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 'h50 + i);  // R1 reach full
    cyc(1, 0, 0, 'h1FF);                     // R1 write on full ignored
    cyc(1, 1, 0, 'h1AA);                     // R1 read+write on full
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0);        // drain past empty
    do_reset(1'b1, 3);                       // R7 threshold 3
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 'h60 + i);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);                         // R5/R6 rewind
    cyc(0, 1, 1, 0);                         // R5 ignored, read happens
    cyc(1, 0, 1, 'h70);                      // R5 ignored, write happens
    cyc(0, 0, 1, 0);                         // R5 rewind to five words
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0);
    do_reset(1'b0, 0);
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[3], 0, int'(lf[15:7]));
    end
    cyc(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule